// File: doc/BRIEF.md
# DRAM Refresh and Self-Refresh Scheduler

This block sits beside the command arbiter of a DDR SDRAM controller and owns every refresh-related command the device receives. A free-running interval timer adds one owed refresh per average refresh period. The owed count is offered to the arbiter as a request. When the arbiter grants, the block closes any open banks with a precharge-all, waits the precharge time, issues an auto refresh and then holds the command bus for the refresh cycle time. Refreshes can be deferred while the grant is withheld. When the owed count reaches its ceiling, the request is flagged as urgent.

A separate level input asks for self refresh. Once granted, the block enters self refresh by sending the refresh pattern while dropping the clock enable. It keeps the clock enable low for as long as the input stays high. When the input falls, it raises the clock enable and then guards a long recovery window during which nothing may be sent. The interval timer is frozen during self refresh and its recovery. Any owed refreshes are discarded when self refresh is left.

Top module: `dram_refresh_sched`

## Requirements
- R1: During and right after reset, clock enable is high, chip select is high (deselect), and busy, request and urgent are all low.
- R2: Counting clocks from reset release, one refresh becomes owed every INTERVAL_CLKS clocks. Clocks spent in self refresh or its recovery window are not counted. The request is high whenever the block is idle and a refresh is owed or self refresh is asked for.
- R3: An auto refresh is clock enable high in that cycle and the one before, with chip select, row strobe and column strobe low and write enable high. With all banks closed, it appears in the cycle after the clock edge that sampled the grant.
- R4: If banks_open is high when the grant is taken, a precharge-all is sent first. This is chip select, row strobe and write enable low, column strobe high, and address bit 10 high. The refresh or self-refresh entry follows exactly T_RP_CLKS cycles later, with no command in between.
- R5: busy rises with the first command of a sequence. After an auto refresh it stays high for exactly T_RFC_CLKS cycles, counting the refresh cycle. No command is sent while busy was high in the previous cycle, except the refresh that ends a precharge wait.
- R6: At most MAX_OWED refreshes are owed, and intervals beyond that are dropped. arb_urgent is high exactly when MAX_OWED are owed. After a long withheld grant, a continuous grant yields exactly MAX_OWED refreshes.
- R7: When MAX_OWED are owed, an auto refresh is served before a pending self-refresh request.
- R8: Self-refresh entry is the auto-refresh pattern with clock enable falling in the same cycle. Clock enable then stays low, with deselect and busy high, while sr_req stays high.
- R9: When sr_req falls in self refresh, clock enable rises with deselect in the next cycle. busy then stays high for exactly T_XSR_CLKS cycles, with no command sent. The owed count is cleared, and the interval timer resumes where it was frozen.
- R10: A grant taken when nothing is owed and self refresh is not asked for has no effect: no command is sent and busy stays low.
- R11: Over any run without self refresh, the number of auto refreshes equals the number of elapsed intervals, including runs where an interval ends on the same edge a refresh is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arb_gnt | input | 1 | Grant from the command arbiter |
| banks_open | input | 1 | High when at least one bank holds an open row |
| sr_req | input | 1 | Level request to enter and stay in self refresh |
| arb_req | output | 1 | Request to the command arbiter |
| arb_urgent | output | 1 | Owed count at its ceiling; must be served next |
| busy | output | 1 | Command bus reserved by this block |
| dram_cke | output | 1 | Clock enable pin |
| dram_cs_n | output | 1 | Chip select, active low |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_a10 | output | 1 | Address bit 10 (all-bank select on precharge) |

## Verification
The interval timer can expire on the same clock edge that a refresh is issued. The owed count then has to take an increment and a decrement at once and end up unchanged. This is provoked by a long stretch of randomly timed grants and random open-bank states. Each of the many issue edges then has a chance of landing on an expiry edge. The result is judged by exact accounting: after a final drain, the number of refreshes seen on the pins must equal the number of intervals elapsed. A second overlap, a full owed count meeting a pending self-refresh request, is set up directly. The bench checks that the refresh goes out before the clock enable drops.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRE,
      ST_RFC,
      ST_SR,
      ST_XSR
   } rs_state_e;

   typedef enum logic [1:0] {
      OP_NONE,
      OP_PREA,
      OP_REF,
      OP_SRE
   } rs_op_e;

   typedef struct packed {
      logic cs_n;
      logic ras_n;
      logic cas_n;
      logic we_n;
      logic a10;
   } rs_pins_t;

   function automatic int rs_max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/refsched_interval.sv
module refsched_interval #(
   parameter int INTERVAL_CLKS = 1040
) (
   input  logic clk,
   input  logic rst_n,
   input  logic freeze,
   output logic tick
);
   localparam int IW = (INTERVAL_CLKS > 2) ? $clog2(INTERVAL_CLKS) : 1;
   localparam logic [IW-1:0] RELOAD = IW'(INTERVAL_CLKS - 1);

   logic [IW-1:0] cnt_q;

   assign tick = !freeze && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= RELOAD;
      end else if (!freeze) begin
         if (cnt_q == '0) cnt_q <= RELOAD;
         else             cnt_q <= cnt_q - 1'b1;
      end
   end

   AST_TIMER_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= RELOAD) else $error("interval counter out of range"); // R2
   AST_FROZEN_TIMER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      freeze |=> (cnt_q == $past(cnt_q))) else $error("timer moved while frozen"); // R9

endmodule

// File: rtl/refsched_debt.sv
module refsched_debt #(
   parameter int MAX_OWED = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic dec,
   input  logic clr,
   output logic owed_nz,
   output logic owed_full
);
   localparam int OW = $clog2(MAX_OWED + 1);
   localparam logic [OW-1:0] CAP = OW'(MAX_OWED);

   logic [OW-1:0] owed_q;

   assign owed_nz   = (owed_q != '0);
   assign owed_full = (owed_q == CAP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         owed_q <= '0;
      end else if (clr) begin
         owed_q <= '0;
      end else begin
         unique case ({tick, dec})
            2'b10:   if (owed_q != CAP) owed_q <= owed_q + 1'b1;
            2'b01:   owed_q <= owed_q - 1'b1;
            default: owed_q <= owed_q;
         endcase
      end
   end

   AST_DEBT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      owed_q <= CAP) else $error("owed count above ceiling"); // R6
   AST_DEC_NEEDS_DEBT: assert property (@(posedge clk) disable iff (!rst_n)
      dec |-> (owed_q != '0)) else $error("refresh issued with nothing owed"); // R11
   AST_BOTH_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && dec && !clr) |=> $stable(owed_q)) else $error("collision changed count"); // R11

endmodule

// File: rtl/refsched_seq.sv
module refsched_seq
   import refsched_pkg::*;
#(
   parameter int T_RP_CLKS  = 3,
   parameter int T_RFC_CLKS = 10,
   parameter int T_XSR_CLKS = 200,
   parameter int CNT_W      = 8
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   gnt,
   input  logic   banks_open,
   input  logic   sr_req,
   input  logic   owed_nz,
   input  logic   owed_full,
   output logic   arb_req,
   output logic   issue_ref,
   output logic   exit_sr,
   output logic   freeze,
   output logic   in_sr,
   output rs_op_e op_q,
   output logic   cke_q,
   output logic   busy_q
);
   localparam logic [CNT_W-1:0] LD_RP  = CNT_W'(T_RP_CLKS - 1);
   localparam logic [CNT_W-1:0] LD_RFC = CNT_W'(T_RFC_CLKS - 1);
   localparam logic [CNT_W-1:0] LD_XSR = CNT_W'(T_XSR_CLKS - 1);

   rs_state_e        st_q;
   logic [CNT_W-1:0] cnt_q;
   logic             sr_mode_q;
   logic             want, pick_sr, take, cnt_done;

   assign want     = owed_nz || sr_req;
   assign pick_sr  = sr_req && !owed_full;
   assign take     = (st_q == ST_IDLE) && gnt && want;
   assign cnt_done = (cnt_q == '0);

   assign arb_req   = (st_q == ST_IDLE) && want;
   assign issue_ref = (take && !banks_open && !pick_sr) ||
                      ((st_q == ST_PRE) && cnt_done && !sr_mode_q);
   assign exit_sr   = (st_q == ST_SR) && !sr_req;
   assign freeze    = (st_q == ST_SR) || (st_q == ST_XSR);
   assign in_sr     = (st_q == ST_SR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         cnt_q     <= '0;
         sr_mode_q <= 1'b0;
         op_q      <= OP_NONE;
         cke_q     <= 1'b1;
         busy_q    <= 1'b0;
      end else begin
         op_q <= OP_NONE;
         unique case (st_q)
            ST_IDLE: begin
               if (take) begin
                  busy_q <= 1'b1;
                  if (banks_open) begin
                     op_q      <= OP_PREA;
                     st_q      <= ST_PRE;
                     cnt_q     <= LD_RP;
                     sr_mode_q <= pick_sr;
                  end else if (pick_sr) begin
                     op_q  <= OP_SRE;
                     cke_q <= 1'b0;
                     st_q  <= ST_SR;
                  end else begin
                     op_q  <= OP_REF;
                     st_q  <= ST_RFC;
                     cnt_q <= LD_RFC;
                  end
               end
            end
            ST_PRE: begin
               if (cnt_done) begin
                  if (sr_mode_q) begin
                     op_q  <= OP_SRE;
                     cke_q <= 1'b0;
                     st_q  <= ST_SR;
                  end else begin
                     op_q  <= OP_REF;
                     st_q  <= ST_RFC;
                     cnt_q <= LD_RFC;
                  end
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            ST_RFC: begin
               if (cnt_done) begin
                  st_q   <= ST_IDLE;
                  busy_q <= 1'b0;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            ST_SR: begin
               if (!sr_req) begin
                  cke_q <= 1'b1;
                  st_q  <= ST_XSR;
                  cnt_q <= LD_XSR;
               end
            end
            ST_XSR: begin
               if (cnt_done) begin
                  st_q   <= ST_IDLE;
                  busy_q <= 1'b0;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   AST_URGENT_BEFORE_SR: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == ST_IDLE) && gnt && owed_full && !banks_open) |=> (op_q == OP_REF && cke_q))
      else $error("self refresh taken ahead of urgent refresh"); // R7
   AST_SR_HOLDS_CKE: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == ST_SR) && sr_req) |=> (!cke_q && busy_q && op_q == OP_NONE))
      else $error("clock enable rose while self refresh held"); // R8
   AST_EXIT_WINDOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_XSR) |-> (cke_q && busy_q && op_q == OP_NONE))
      else $error("command during recovery window"); // R9
   AST_PREA_THEN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (op_q == OP_PREA) |-> (st_q == ST_PRE && busy_q))
      else $error("precharge-all outside wait"); // R4

endmodule

// File: rtl/refsched_pins.sv
module refsched_pins
   import refsched_pkg::*;
#(
   parameter bit IDLE_IS_NOP = 1'b0
) (
   input  rs_op_e   op,
   output rs_pins_t pins
);
   logic idle_cs_n;

   generate
      if (IDLE_IS_NOP) begin : g_idle_nop
         assign idle_cs_n = 1'b0;
      end else begin : g_idle_desel
         assign idle_cs_n = 1'b1;
      end
   endgenerate

   always_comb begin
      unique case (op)
         OP_PREA:        pins = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0, a10: 1'b1};
         OP_REF, OP_SRE: pins = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, a10: 1'b0};
         default:        pins = '{cs_n: idle_cs_n, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, a10: 1'b0};
      endcase
   end

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
   import refsched_pkg::*;
#(
   parameter int INTERVAL_CLKS = 1040,
   parameter int T_RFC_CLKS    = 10,
   parameter int T_RP_CLKS     = 3,
   parameter int T_XSR_CLKS    = 200,
   parameter int MAX_OWED      = 8,
   parameter bit IDLE_IS_NOP   = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arb_gnt,
   input  logic banks_open,
   input  logic sr_req,
   output logic arb_req,
   output logic arb_urgent,
   output logic busy,
   output logic dram_cke,
   output logic dram_cs_n,
   output logic dram_ras_n,
   output logic dram_cas_n,
   output logic dram_we_n,
   output logic dram_a10
);
   localparam int WAIT_MAX = rs_max3(T_RP_CLKS, T_RFC_CLKS, T_XSR_CLKS);
   localparam int CNT_W    = $clog2(WAIT_MAX + 1);

   generate
      if (INTERVAL_CLKS < 2) begin : g_bad_interval
         $error("INTERVAL_CLKS must be at least 2");
      end
      if (T_RP_CLKS < 1 || T_RFC_CLKS < 1 || T_XSR_CLKS < 1) begin : g_bad_wait
         $error("wait times must be at least one clock");
      end
      if (MAX_OWED < 1) begin : g_bad_owed
         $error("MAX_OWED must be at least 1");
      end
   endgenerate

   logic     tick, freeze, issue_ref, exit_sr, in_sr;
   logic     owed_nz, owed_full;
   rs_op_e   op_q;
   rs_pins_t pins;

   refsched_interval #(.INTERVAL_CLKS(INTERVAL_CLKS)) u_interval (
      .clk(clk), .rst_n(rst_n), .freeze(freeze), .tick(tick)
   );

   refsched_debt #(.MAX_OWED(MAX_OWED)) u_debt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .dec(issue_ref), .clr(exit_sr),
      .owed_nz(owed_nz), .owed_full(owed_full)
   );

   refsched_seq #(
      .T_RP_CLKS(T_RP_CLKS), .T_RFC_CLKS(T_RFC_CLKS),
      .T_XSR_CLKS(T_XSR_CLKS), .CNT_W(CNT_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .gnt(arb_gnt), .banks_open(banks_open),
      .sr_req(sr_req), .owed_nz(owed_nz), .owed_full(owed_full),
      .arb_req(arb_req), .issue_ref(issue_ref), .exit_sr(exit_sr),
      .freeze(freeze), .in_sr(in_sr), .op_q(op_q), .cke_q(dram_cke), .busy_q(busy)
   );

   refsched_pins #(.IDLE_IS_NOP(IDLE_IS_NOP)) u_pins (
      .op(op_q), .pins(pins)
   );

   assign arb_urgent = owed_full;
   assign dram_cs_n  = pins.cs_n;
   assign dram_ras_n = pins.ras_n;
   assign dram_cas_n = pins.cas_n;
   assign dram_we_n  = pins.we_n;
   assign dram_a10   = pins.a10;

   AST_BUSY_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !arb_req) else $error("request while bus reserved"); // R5
   AST_CKE_LOW_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      !dram_cke |-> (busy && in_sr)) else $error("clock enable low outside self refresh"); // R8
   AST_NO_TICK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      freeze |-> !tick) else $error("interval expired while frozen"); // R9
   AST_URGENT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_urgent && !busy) |-> arb_req) else $error("urgent without request"); // R6

endmodule

// File: tb/dram_refresh_sched_tb.sv
`timescale 1ns/1ps
module dram_refresh_sched_tb;
   localparam int IV = 60, RP = 3, RFC = 4, XSR = 20, MO = 8;

   logic clk = 1'b0, rst_n = 1'b0, gnt = 1'b0, bopen = 1'b0, srq = 1'b0;
   logic arb_req, arb_urgent, busy, cke, cs_n, ras_n, cas_n, we_n, a10;
   logic cke_d = 1'b1;
   int   total = 0, bad = 0, ecnt = 0, ref_cnt = 0, since_prea = 1000;
   logic busy_d = 1'b0;

   always #2 clk = ~clk;

   dram_refresh_sched #(
      .INTERVAL_CLKS(IV), .T_RFC_CLKS(RFC), .T_RP_CLKS(RP),
      .T_XSR_CLKS(XSR), .MAX_OWED(MO), .IDLE_IS_NOP(1'b0)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .arb_gnt(gnt), .banks_open(bopen), .sr_req(srq),
      .arb_req(arb_req), .arb_urgent(arb_urgent), .busy(busy),
      .dram_cke(cke), .dram_cs_n(cs_n), .dram_ras_n(ras_n), .dram_cas_n(cas_n),
      .dram_we_n(we_n), .dram_a10(a10)
   );

   always @(posedge clk or negedge rst_n)
      if (!rst_n) ecnt <= 0; else ecnt <= ecnt + 1;
   always @(posedge clk) cke_d <= cke;

   function automatic bit pat_ref();  return !cs_n && !ras_n && !cas_n && we_n; endfunction
   function automatic bit is_ref();   return cke && cke_d && pat_ref(); endfunction
   function automatic bit is_sre();   return !cke && cke_d && pat_ref(); endfunction
   function automatic bit is_prea();  return !cs_n && !ras_n && cas_n && !we_n && a10; endfunction
   function automatic bit is_idle();  return cs_n || (ras_n && cas_n && we_n); endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // monitor: command spacing around busy windows (R4, R5) and refresh count (R11)
   always @(negedge clk) begin
      if (!rst_n) begin
         ref_cnt    = 0;
         since_prea = 1000;
         busy_d     = 1'b0;
      end else begin
         since_prea = since_prea + 1;
         if (!is_idle()) begin
            if (busy_d)
               chk((is_ref() || is_sre()) && since_prea == RP, "R5 command inside busy", since_prea, RP);
            if (is_prea()) since_prea = 0;
            if (is_ref()) ref_cnt = ref_cnt + 1;
         end
         busy_d = busy;
      end
   end

   task automatic do_reset();
      rst_n = 1'b0; gnt = 1'b0; srq = 1'b0; bopen = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wait_to(input int n);
      while (ecnt < n) @(negedge clk);
   endtask

   task automatic wait_req(input int limit);
      int k = 0;
      while (!arb_req && k < limit) begin @(negedge clk); k++; end
   endtask

   initial begin
      int len, badc, k, s_edge, x_edge, z_edge;
      void'($urandom(32'd4242));

      // R1 reset state
      do_reset();
      chk(cke && cs_n && !busy && !arb_req && !arb_urgent, "R1 reset state",
          {cke, cs_n, busy, arb_req, arb_urgent}, 5'b11000);

      // R10 grant with nothing owed
      gnt = 1'b1; badc = 0;
      repeat (20) begin @(negedge clk); if (!is_idle() || busy) badc++; end
      gnt = 1'b0;
      chk(badc == 0, "R10 idle grant", badc, 0);

      // R2 first interval
      wait_req(200);
      chk(ecnt == IV, "R2 first request edge", ecnt, IV);

      // R3 / R5 refresh with banks closed
      gnt = 1'b1;
      @(negedge clk);
      chk(is_ref(), "R3 refresh one cycle after grant", {cs_n, ras_n, cas_n, we_n}, 4'b0001);
      gnt = 1'b0; len = 0;
      while (busy && len < 100) begin len++; @(negedge clk); end
      chk(len == RFC, "R5 busy after refresh", len, RFC);
      chk(!arb_req, "R2 request cleared after refresh", arb_req, 0);

      // R4 precharge-all first
      wait_req(200);
      chk(ecnt == 2 * IV, "R2 second request edge", ecnt, 2 * IV);
      bopen = 1'b1; gnt = 1'b1;
      @(negedge clk);
      chk(is_prea() && busy, "R4 precharge-all with a10", {cs_n, ras_n, cas_n, we_n, a10}, 5'b00101);
      gnt = 1'b0; bopen = 1'b0; k = 0;
      do begin @(negedge clk); k++; end while (is_idle() && k < 50);
      chk(is_ref() && k == RP, "R4 refresh after precharge wait", k, RP);
      len = 0;
      while (busy && len < 100) begin len++; @(negedge clk); end
      chk(len == RFC, "R5 busy after refresh following precharge", len, RFC);

      // R6 saturation
      do_reset();
      wait_to(9 * IV + 5);
      chk(arb_urgent && arb_req, "R6 urgent at ceiling", arb_urgent, 1);
      gnt = 1'b1;
      @(negedge clk);
      chk(is_ref() && !arb_urgent, "R6 urgent drops after one refresh", arb_urgent, 0);
      wait_to(10 * IV - 5);
      gnt = 1'b0;
      @(negedge clk); #1;
      chk(ref_cnt == MO, "R6 refreshes after withheld grant", ref_cnt, MO);
      chk(!arb_req, "R6 debt drained", arb_req, 0);

      // R7 / R8 / R9 self refresh
      do_reset();
      wait_to(9 * IV + 5);
      srq = 1'b1; gnt = 1'b1;
      @(negedge clk);
      chk(is_ref() && cke, "R7 urgent refresh before self refresh", cke, 1);
      k = 0;
      do begin @(negedge clk); k++; end while (is_idle() && k < 30);
      chk(is_sre(), "R8 self-refresh entry pattern", {cke, cs_n, ras_n, cas_n, we_n}, 5'b00001);
      s_edge = ecnt; gnt = 1'b0; badc = 0;
      repeat (300) begin
         @(negedge clk);
         if (cke || !cs_n || arb_req || !busy) badc++;
      end
      chk(badc == 0, "R8 held in self refresh", badc, 0);
      srq = 1'b0;
      @(negedge clk);
      x_edge = ecnt;
      chk(cke && cs_n && busy, "R9 exit raises cke with deselect", {cke, cs_n, busy}, 3'b111);
      len = 0; badc = 0;
      while (busy && len < 100) begin
         if (!is_idle()) badc++;
         len++; @(negedge clk);
      end
      z_edge = ecnt;
      chk(len == XSR && badc == 0, "R9 recovery window length", len, XSR);
      chk(!arb_req && z_edge == x_edge + XSR, "R9 owed cleared at exit", arb_req, 0);
      wait_req(200);
      chk(ecnt == z_edge + 10 * IV - s_edge, "R9 frozen timer resumes", ecnt, z_edge + 10 * IV - s_edge);

      // R11 random grants, then exact accounting
      do_reset();
      while (ecnt < 1000) begin
         gnt   = ($urandom % 3) == 0;
         bopen = $urandom % 2;
         @(negedge clk);
      end
      gnt = 1'b1; bopen = 1'b0;
      wait_to(20 * IV + 30);
      @(negedge clk); #1;
      chk(ref_cnt == 20, "R11 refreshes match intervals", ref_cnt, 20);
      chk(!arb_req && !busy, "R11 idle after drain", {arb_req, busy}, 0);
      gnt = 1'b0;

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule